// File: doc/BRIEF.md
# Serial UART with Error-Tagged Receive Queue

This block is a full-duplex asynchronous serial port. Transmit and receive run on their own, each with a 16-entry queue between the line and the host. The host writes characters into the transmit queue through a valid/ready port. It reads characters from the receive queue through a second valid/ready port. Every receive entry is 12 bits wide: the 8 data bits plus four error flags for that character. Software can therefore tell which character was damaged without a separate status read.

Both directions use 16x oversampling. A single integer divisor sets the tick rate, giving bit rate = f_clk / (16 * (baud_div + 1)). A 7.3728 MHz module clock with divisor 0 reaches 460.8 kbit/s. The frame is one start bit, eight data bits sent LSB first, an optional even or odd parity bit, and one stop bit. Parity, framing, break and overrun are detected on reception.

Four interrupt sources are tracked: receive level, transmit level, modem-status change and receive error. Each source has a sticky raw bit and its own mask bit. The raw bits are cleared by pulsing a write-one-to-clear input. One output line is raised while any unmasked raw bit is set.

Back-pressure rules:
- A transmit character is taken in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low only while the transmit queue is full.
- `rx_valid` is high while the receive queue holds an entry. `rx_data` shows the oldest entry, and it is removed on a cycle where `rx_ready` is also high.
- The receiver cannot be stalled. A character that completes while the receive queue is full is lost.

Top module: `uart_etag_top`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `rx_valid` is 0, `irq_raw` is 0 and `irq` is 0.
- R2: One oversampling tick occurs every `baud_div`+1 clocks, and each bit lasts 16 ticks. A transmitted frame is a 0 start bit, then data LSB first, then a parity bit when `par_en` is 1, then a 1 stop bit. The parity bit is the XOR of the data when `par_odd` is 0 and its inverse when `par_odd` is 1.
- R3: The transmit queue holds 16 characters waiting behind the one being shifted. `tx_ready` is 0 when the queue is full, and it falls only after an accepted write.
- R4: A received character appears at `rx_data[7:0]` with bits 11:8 clear when it has no error. The entry stays stable while `rx_valid` is 1 and `rx_ready` is 0. A low pulse on `rxd` shorter than half a bit produces no entry.
- R5: With `par_en` set, a received parity bit that differs from the rule of R2 sets bit 9 of the entry.
- R6: A 0 stop bit on a character that is not a break sets bit 8 of the entry.
- R7: When the line stays low through the start, data, parity (if enabled) and stop bits, one entry is stored with data 0, bit 10 set and bits 9 and 8 clear. No further entry is stored until the line returns high.
- R8: A character that completes while the receive queue is full is dropped. Bit 11 is then set on the next entry stored.
- R9: Raw bit 0 is set when the receive queue fills from 7 to 8 entries.
- R10: Raw bit 1 is set when the transmit queue drains from 9 to 8 entries.
- R11: Raw bit 2 is set on either edge of `modem_in`, three clocks after the edge.
- R12: Raw bit 3 is set when a character completes with a parity, framing or break condition, or is dropped for overrun.
- R13: `irq` is 1 exactly when a raw bit and its mask bit are both 1. A 1 on `irq_clr[k]` clears raw bit k, except in a cycle where that source sets it again, in which case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Tick divisor: tick period is baud_div+1 clocks |
| par_en | input | 1 | Adds a parity bit to each frame in both directions |
| par_odd | input | 1 | Selects odd parity (1) or even parity (0) |
| tx_valid | input | 1 | Host offers a transmit character |
| tx_ready | output | 1 | Transmit queue has room |
| tx_data | input | 8 | Transmit character |
| rx_valid | output | 1 | Receive queue holds an entry |
| rx_ready | input | 1 | Host takes the shown entry |
| rx_data | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| modem_in | input | 1 | Modem status line watched for changes |
| irq_mask | input | 4 | Per-source enable: bit0 rx, bit1 tx, bit2 modem, bit3 error |
| irq_clr | input | 4 | Write-one-to-clear pulse per raw bit |
| irq_raw | output | 4 | Sticky raw source bits |
| irq | output | 1 | Combined interrupt |

## Verification
A raw-bit set and the host's clear of the same bit can land in one clock. The bench provokes this by toggling `modem_in` and then pulsing `irq_clr[2]` for exactly the one cycle in which the synchronised edge is being registered. It judges the result by the raw bit staying 1 after the pulse. A plain clear on a later cycle must still drop the bit. A second case of the same kind is a character that completes while the receive queue is full: the drop and the overrun tag must both happen, and the tag must appear on the character stored after the host makes room.

// File: rtl/uart_etag_pkg.sv
package uart_etag_pkg;
  localparam int DATA_W = 8;
  localparam int RXE_W  = 12;
  localparam int NSRC   = 4;
  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_MS  = 2;
  localparam int SRC_ERR = 3;

  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              par;
    logic              frm;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_etag_fifo.sv
module uart_etag_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic [AW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      if (do_push && !do_pop)      count <= count + (AW+1)'(1);
      else if (do_pop && !do_push) count <= count - (AW+1)'(1);
    end
  end
endmodule

// File: rtl/uart_etag_baud.sv
module uart_etag_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_etag_tx.sv
module uart_etag_tx
  import uart_etag_pkg::*;
#(
  parameter int OVS  = 16,
  localparam int TCW = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              txd
);
  logic [DATA_W+2:0] sh;
  logic [3:0]        nbits, bcnt;
  logic [TCW-1:0]    tcnt;
  logic              pbit;

  assign pbit = (^din) ^ par_odd;
  assign txd  = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '1;
      nbits <= '0;
      bcnt  <= '0;
      tcnt  <= '0;
      busy  <= 1'b0;
    end else if (start && !busy) begin
      sh    <= {1'b1, par_en ? pbit : 1'b1, din, 1'b0};
      nbits <= par_en ? 4'd11 : 4'd10;
      bcnt  <= '0;
      tcnt  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == TCW'(OVS-1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[DATA_W+2:1]};
        bcnt <= bcnt + 4'd1;
        if (bcnt == nbits - 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + TCW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_etag_rx.sv
module uart_etag_rx
  import uart_etag_pkg::*;
#(
  parameter int OVS  = 16,
  localparam int TCW = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] o_data,
  output logic              o_frm,
  output logic              o_par,
  output logic              o_brk
);
  rx_state_t         st;
  logic              s1, s2;
  logic [TCW-1:0]    tcnt;
  logic [2:0]        bidx;
  logic [DATA_W-1:0] sh;
  logic              pbit, seen1;
  logic              at_centre, is_brk;

  assign at_centre = tick && (tcnt == TCW'(OVS-1));
  assign is_brk    = !seen1 && !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      tcnt   <= '0;
      bidx   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      seen1  <= 1'b0;
      done   <= 1'b0;
      o_data <= '0;
      o_frm  <= 1'b0;
      o_par  <= 1'b0;
      o_brk  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (tick && !s2) begin
          tcnt <= '0;
          st   <= RX_START;
        end
        RX_START: if (tick) begin
          if (tcnt == TCW'(OVS/2-1)) begin
            tcnt  <= '0;
            bidx  <= '0;
            seen1 <= 1'b0;
            st    <= s2 ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + TCW'(1);
          end
        end
        RX_DATA: if (at_centre) begin
          tcnt  <= '0;
          sh    <= {s2, sh[DATA_W-1:1]};
          seen1 <= seen1 | s2;
          bidx  <= bidx + 3'd1;
          if (bidx == 3'd7) st <= par_en ? RX_PAR : RX_STOP;
        end else if (tick) begin
          tcnt <= tcnt + TCW'(1);
        end
        RX_PAR: if (at_centre) begin
          tcnt  <= '0;
          pbit  <= s2;
          seen1 <= seen1 | s2;
          st    <= RX_STOP;
        end else if (tick) begin
          tcnt <= tcnt + TCW'(1);
        end
        RX_STOP: if (at_centre) begin
          tcnt   <= '0;
          done   <= 1'b1;
          o_data <= sh;
          o_brk  <= is_brk;
          o_frm  <= !s2 && seen1;
          o_par  <= par_en && seen1 && (pbit != ((^sh) ^ par_odd));
          st     <= s2 ? RX_IDLE : RX_HOLD;
        end else if (tick) begin
          tcnt <= tcnt + TCW'(1);
        end
        RX_HOLD: if (s2) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_etag_top.sv
module uart_etag_top
  import uart_etag_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int OVS      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [RXE_W-1:0]  rx_data,
  output logic              txd,
  input  logic              rxd,
  input  logic              modem_in,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic [NSRC-1:0]   irq_clr,
  output logic [NSRC-1:0]   irq_raw,
  output logic              irq
);
  localparam int TX_AW = $clog2(TX_DEPTH);
  localparam int RX_AW = $clog2(RX_DEPTH);

  logic              tick;
  logic              tx_full, tx_empty, tx_busy, tx_pop, tx_push_ok;
  logic [TX_AW:0]    tx_count;
  logic [DATA_W-1:0] tx_head;
  logic              rx_full, rx_empty, rx_push_ok, rx_pop_ok;
  logic [RX_AW:0]    rx_count;
  logic              rx_done, rx_frm, rx_par, rx_brk;
  logic [DATA_W-1:0] rx_byte;
  logic              ovr_pend;
  rx_entry_t         rx_wentry;
  logic              ms1, ms2, ms3;
  logic [NSRC-1:0]   src_set;

  uart_etag_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick));

  assign tx_push_ok = tx_valid && !tx_full;
  assign tx_pop     = !tx_busy && !tx_empty;
  assign tx_ready   = !tx_full;

  uart_etag_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_count));

  uart_etag_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en),
    .par_odd(par_odd), .start(tx_pop), .din(tx_head), .busy(tx_busy),
    .txd(txd));

  uart_etag_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .done(rx_done), .o_data(rx_byte),
    .o_frm(rx_frm), .o_par(rx_par), .o_brk(rx_brk));

  assign rx_push_ok = rx_done && !rx_full;
  assign rx_pop_ok  = rx_ready && !rx_empty;
  assign rx_valid   = !rx_empty;
  assign rx_wentry  = '{ovr: ovr_pend, brk: rx_brk, par: rx_par,
                        frm: rx_frm, data: rx_byte};

  uart_etag_fifo #(.W(RXE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_done), .wdata(rx_wentry),
    .pop(rx_ready), .rdata(rx_data), .full(rx_full), .empty(rx_empty),
    .count(rx_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pend <= 1'b0;
      ms1      <= 1'b0;
      ms2      <= 1'b0;
      ms3      <= 1'b0;
    end else begin
      ms1 <= modem_in;
      ms2 <= ms1;
      ms3 <= ms2;
      if (rx_done && rx_full) ovr_pend <= 1'b1;
      else if (rx_push_ok)    ovr_pend <= 1'b0;
    end
  end

  always_comb begin
    src_set          = '0;
    src_set[SRC_RX]  = rx_push_ok && !rx_pop_ok &&
                       (rx_count == (RX_AW+1)'(RX_DEPTH/2-1));
    src_set[SRC_TX]  = tx_pop && !tx_push_ok &&
                       (tx_count == (TX_AW+1)'(TX_DEPTH/2+1));
    src_set[SRC_MS]  = ms2 ^ ms3;
    src_set[SRC_ERR] = rx_done && (rx_frm || rx_par || rx_brk || rx_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_raw <= '0;
    else        irq_raw <= (irq_raw & ~irq_clr) | src_set;
  end

  assign irq = |(irq_raw & irq_mask);
endmodule

// File: rtl/uart_etag_chk.sv
module uart_etag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [11:0] rx_data,
  input logic [3:0]  irq_mask,
  input logic [3:0]  irq_clr,
  input logic [3:0]  irq_raw,
  input logic        irq
);
  // R3
  tx_fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_data[10]) |-> (rx_data[7:0] == 8'h00));

  // R13
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 4'h0) |-> !irq);

  for (genvar k = 0; k < 4; k++) begin : g_clr
    // R13
    raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_raw[k]) |-> $past(irq_clr[k]));
  end
endmodule

bind uart_etag_top uart_etag_chk u_chk (.*);

// File: tb/uart_etag_top_tb.sv
module uart_etag_top_tb;
  localparam int P   = 4;
  localparam int BIT = 16 * P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'(P - 1);
  logic        par_en = 1'b0, par_odd = 1'b0;
  logic        tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, rx_valid, txd, irq;
  logic [11:0] rx_data;
  logic        modem_in = 1'b0, loop = 1'b0, drv = 1'b1;
  logic [3:0]  irq_mask = '0, irq_clr = '0, irq_raw;
  logic        rxd;
  int          n_chk = 0, n_err = 0;

  assign rxd = loop ? txd : drv;
  always #5 clk = ~clk;

  uart_etag_top u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .par_en(par_en),
    .par_odd(par_odd), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .txd(txd), .rxd(rxd), .modem_in(modem_in),
    .irq_mask(irq_mask), .irq_clr(irq_clr), .irq_raw(irq_raw), .irq(irq));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop(output logic [11:0] e);
    int t = 0;
    while (!rx_valid && t < 3000) begin @(negedge clk); t++; end
    e = rx_valid ? rx_data : 12'hFFF;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    irq_clr = m;
    @(negedge clk);
    irq_clr = '0;
  endtask

  // pmode 1 flips the parity bit
  task automatic send(input logic [7:0] d, input bit bad_par, input bit stopv);
    drv = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin drv = d[i]; repeat (BIT) @(negedge clk); end
    if (par_en) begin
      drv = (^d) ^ par_odd ^ bad_par; repeat (BIT) @(negedge clk);
    end
    drv = stopv; repeat (BIT) @(negedge clk);
    drv = 1'b1;  repeat (BIT) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 txd", txd, 1);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 irq_raw", irq_raw, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_tx_frame();
    logic [10:0] exp;
    int t = 0;
    par_en = 1'b1; par_odd = 1'b0;
    exp = {1'b1, 1'b0, 8'hC5, 1'b0};
    push(8'hC5);
    while (txd && t < 2000) begin @(negedge clk); t++; end
    repeat (BIT/2) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      check($sformatf("R2 bit%0d", k), txd, exp[k]);
      if (k < 10) repeat (BIT) @(negedge clk);
    end
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_loopback();
    logic [11:0] e;
    loop = 1'b1; par_en = 1'b0;
    push(8'hA5); pop(e);
    check("R4 loop plain", e, 12'h0A5);
    par_en = 1'b1; par_odd = 1'b1;
    push(8'h81); pop(e);
    check("R4 loop odd parity", e, 12'h081);
    repeat (BIT) @(negedge clk);
    loop = 1'b0;
  endtask

  task automatic t_glitch();
    par_en = 1'b0;
    drv = 1'b0; repeat (3*P) @(negedge clk);
    drv = 1'b1; repeat (2*BIT) @(negedge clk);
    check("R4 glitch rejected", rx_valid, 0);
  endtask

  task automatic t_errors();
    logic [11:0] e;
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C, 1'b1, 1'b1); pop(e);
    check("R5 parity error", e, 12'h23C);
    check("R12 error raw", irq_raw[3], 1);
    irq_mask = 4'b1000; #1;
    check("R13 masked in", irq, 1);
    irq_mask = 4'b0111; #1;
    check("R13 masked out", irq, 0);
    clear(4'b1000);
    check("R13 clear", irq_raw[3], 0);
    par_en = 1'b0;
    send(8'h55, 1'b0, 1'b0); pop(e);
    check("R6 framing", e, 12'h155);
    send(8'h00, 1'b0, 1'b0);
    repeat (4*BIT) @(negedge clk);
    pop(e);
    check("R7 break", e, 12'h400);
    check("R7 single entry", rx_valid, 0);
    irq_mask = '0;
    clear(4'hF);
  endtask

  task automatic t_modem();
    modem_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 edge sets", irq_raw[2], 1);
    irq_mask = 4'b0100; #1;
    check("R13 modem irq", irq, 1);
    clear(4'b0100);
    check("R11 cleared", irq_raw[2], 0);
    modem_in = 1'b0;
    @(negedge clk); @(negedge clk);
    irq_clr = 4'b0100;
    @(negedge clk);
    irq_clr = '0;
    check("R13 set wins", irq_raw[2], 1);
    clear(4'b0100);
    check("R13 later clear", irq_raw[2], 0);
    irq_mask = '0;
  endtask

  task automatic t_tx_fill();
    int t = 0;
    for (int i = 0; i < 17; i++) begin
      tx_valid = 1'b1; tx_data = 8'(i); @(negedge clk);
    end
    tx_valid = 1'b0;
    check("R3 full", tx_ready, 0);
    check("R10 not yet", irq_raw[1], 0);
    while (!irq_raw[1] && t < 20000) begin @(negedge clk); t++; end
    check("R10 drain to half", irq_raw[1], 1);
    check("R3 room again", tx_ready, 1);
    clear(4'b0010);
    check("R10 clear", irq_raw[1], 0);
    repeat (10*11*BIT) @(negedge clk);
  endtask

  task automatic t_overrun();
    logic [11:0] e;
    par_en = 1'b0;
    clear(4'hF);
    for (int i = 0; i < 16; i++) begin
      send(8'(i + 1), 1'b0, 1'b1);
      if (i == 6) check("R9 below half", irq_raw[0], 0);
      if (i == 7) check("R9 half", irq_raw[0], 1);
    end
    check("R12 no error yet", irq_raw[3], 0);
    send(8'hEE, 1'b0, 1'b1);
    check("R12 overrun error", irq_raw[3], 1);
    pop(e);
    check("R8 first kept", e, 12'h001);
    send(8'h77, 1'b0, 1'b1);
    for (int i = 2; i <= 16; i++) begin
      pop(e);
      check($sformatf("R8 entry%0d", i), e, 12'(i));
    end
    pop(e);
    check("R8 tagged next", e, 12'h877);
    check("R8 drop", rx_valid, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_frame();
    t_loopback();
    t_glitch();
    t_errors();
    t_modem();
    t_tx_fill();
    t_overrun();
    finish_run();
  end
endmodule